// File: doc/BRIEF.md
# Polled Peripheral Bus Host Controller

This block is the processor-side end of a parallel peripheral bus on which every transfer is found by polling. It holds an 8-bit transfer register that the sequencer can load and read back. Every byte sent to a device, every byte received from one, and every device address passes through this register. A second 8-bit latch, which software cannot read, holds the address of the selected device. That latch is filled from the transfer register only by a select command.

The sequencer issues 8-bit bus commands. A select command copies the transfer register into the address latch. It then fires the address strobe after a programmable delay and holds it for a programmable width. Two other command bits fire the data-out strobe and the device-specific control strobe, each for its own programmable width. The controller owns the processor-busy handshake flag. When a device pulls the input strobe low, the controller captures the 9-bit input bus: the low eight bits go into the transfer register, the ninth into a status bit, and the busy flag is forced active again.

There is no interlock and no interrupt. A busy device can still be written, and a new command may restart a strobe that is still running. The device ready line, the busy flag, the ninth input bit and a strobe-in-progress bit are offered only as status for polling. All bus pins are active low. Every delay and width is given in nanoseconds and turned into clock cycles from the clock-frequency parameter.

Top module: `pio_host_ctrl`

## Requirements
- R1: After reset the transfer register, the address latch and the ninth-bit status are 0. All bus outputs `obN`, `abN`, `absN`, `obsN` and `cbsN` are all ones. `cpbN` is low (busy active), and `strobeBusy` is 0.
- R2: A host write (`kWrEn`) loads `kWrData` into the transfer register at the clock edge. From the next cycle, `kValue` shows that value and `obN` shows its inverse.
- R3: A recognised command with `cmdCode[7:6]==2'b11` (for example 0xC0) copies the transfer register into the address latch at the command edge, and `abN` shows its inverse. The latch keeps its value through later host writes and through other commands.
- R4: Let the select command be accepted at edge E. `absN` is low after edges E+SEL_DELAY through E+SEL_DELAY+SEL_WIDTH-1, which is SEL_WIDTH cycles. It is high otherwise. Both counts are derived from nanosecond parameters at the clock rate.
- R5: A recognised command with `cmdCode[5]==1` (for example 0x20) drives `obsN` low for OUT_WIDTH cycles, starting in the cycle after the command edge.
- R6: A recognised command with `cmdCode[4]==1` (for example 0x10) drives `cbsN` low for CTL_WIDTH cycles, starting in the cycle after the command edge.
- R7: A command is recognised only when `cmdCode[3:0]==0`. Any other code has no effect on the strobes or on the address latch.
- R8: Nothing interlocks the bus. A repeated command during an active strobe restarts that strobe's full timing from the new edge. A host write is accepted whatever the level of `rbN`.
- R9: A host write of the busy flag (`busyWrEn`, `busyWrVal`) sets the flag, with 1 meaning busy. `cpbN` is the inverse of the flag, and `cpuBusy` shows the flag.
- R10: An edge where `ibsN` is sampled low after being sampled high does three things: it loads `~ibN[7:0]` into the transfer register, loads `~ibN[8]` into `inBit9`, and sets the busy flag. Holding `ibsN` low for longer does not capture again.
- R11: When a capture and a host write of the transfer register or of the busy flag fall on the same edge, the capture wins.
- R12: `devReady` is the inverse of `rbN`, with no delay. `strobeBusy` is 1 while any strobe delay or strobe pulse is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| kWrEn | input | 1 | Host write of the transfer register |
| kWrData | input | 8 | Data for the host write |
| kValue | output | 8 | Transfer register readback |
| cmdValid | input | 1 | Bus command present this cycle |
| cmdCode | input | 8 | Bus command code |
| busyWrEn | input | 1 | Host write of the busy flag |
| busyWrVal | input | 1 | New busy flag value (1 = busy) |
| ibN | input | 9 | Input data bus, active low |
| ibsN | input | 1 | Input strobe from device, active low |
| rbN | input | 1 | Device ready line, low = ready |
| obN | output | 8 | Output data bus, active low |
| abN | output | 8 | Address bus, active low |
| absN | output | 1 | Address strobe, active low |
| obsN | output | 1 | Data-out strobe, active low |
| cbsN | output | 1 | Control strobe, active low |
| cpbN | output | 1 | Processor busy, active low |
| devReady | output | 1 | Status: selected device ready |
| cpuBusy | output | 1 | Status: busy flag |
| inBit9 | output | 1 | Status: ninth captured input bit |
| strobeBusy | output | 1 | Status: a strobe timer is running |

## Verification
Register loads, address latching and captures take effect at the accepting edge, so they are checked at the falling edge straight after it. The address strobe is checked one cycle before, at the first cycle of, at the last cycle of and one cycle after its low window, counted from the command edge as SEL_DELAY and SEL_DELAY+SEL_WIDTH-1. The data-out and control strobes are checked at offsets 0, WIDTH-1 and WIDTH. A retriggered strobe is checked past the point where the first pulse would have ended. Every output is sampled at the falling clock edge, and inputs change only at falling edges.

// File: rtl/pio_host_pkg.sv
package pio_host_pkg;

  typedef struct packed {
    logic loadAb;   // copy transfer register into address latch
    logic capture;  // take the input bus into the transfer register
    logic hostWr;   // host write of the transfer register
  } ctrlStrobes_t;

  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned clkMhz);
    int unsigned c;
    c = (ns * clkMhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/pio_pulse_timer.sv
module pio_pulse_timer #(
  parameter int unsigned DELAY_CYC = 0,
  parameter int unsigned WIDTH_CYC = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic fire,
  output logic pulseOn,
  output logic running
);
  localparam int unsigned TOTAL = DELAY_CYC + WIDTH_CYC;
  localparam int unsigned CW = $clog2(TOTAL + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             remain <= '0;
    else if (fire)         remain <= CW'(TOTAL);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign running = (remain != '0);
  assign pulseOn = running && (remain <= CW'(WIDTH_CYC));

  // R8
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fire && !running) |=> !running);

  // R4
  pulse_ends_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(pulseOn));

  // R8
  fire_restarts_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> running);

endmodule

// File: rtl/pio_host_control.sv
module pio_host_control
  import pio_host_pkg::*;
#(
  parameter int unsigned SEL_DELAY_CYC = 200,
  parameter int unsigned SEL_WIDTH_CYC = 860,
  parameter int unsigned OUT_WIDTH_CYC = 100,
  parameter int unsigned CTL_WIDTH_CYC = 100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [7:0]   cmdCode,
  input  logic         kWrEn,
  input  logic         busyWrEn,
  input  logic         busyWrVal,
  input  logic         ibsN,
  output ctrlStrobes_t strb,
  output logic         absOn,
  output logic         obsOn,
  output logic         cbsOn,
  output logic         strobeBusy,
  output logic         cpuBusy
);
  logic cmdOk, selFire, outFire, ctlFire;
  logic ibsPrevN, selRun, outRun, ctlRun;

  assign cmdOk   = cmdValid && (cmdCode[3:0] == 4'h0);
  assign selFire = cmdOk && (cmdCode[7:6] == 2'b11);
  assign outFire = cmdOk && cmdCode[5];
  assign ctlFire = cmdOk && cmdCode[4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ibsPrevN <= 1'b1;
    else       ibsPrevN <= ibsN;
  end

  assign strb.capture = ibsPrevN && !ibsN;
  assign strb.loadAb  = selFire;
  assign strb.hostWr  = kWrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cpuBusy <= 1'b1;
    else if (strb.capture)  cpuBusy <= 1'b1;
    else if (busyWrEn)      cpuBusy <= busyWrVal;
  end

  pio_pulse_timer #(.DELAY_CYC(SEL_DELAY_CYC), .WIDTH_CYC(SEL_WIDTH_CYC)) selTimer (
    .clk(clk), .rstN(rstN), .fire(selFire), .pulseOn(absOn), .running(selRun));

  pio_pulse_timer #(.DELAY_CYC(0), .WIDTH_CYC(OUT_WIDTH_CYC)) outTimer (
    .clk(clk), .rstN(rstN), .fire(outFire), .pulseOn(obsOn), .running(outRun));

  pio_pulse_timer #(.DELAY_CYC(0), .WIDTH_CYC(CTL_WIDTH_CYC)) ctlTimer (
    .clk(clk), .rstN(rstN), .fire(ctlFire), .pulseOn(cbsOn), .running(ctlRun));

  assign strobeBusy = selRun || outRun || ctlRun;

  // R10
  capture_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> cpuBusy);

  // R9
  busy_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !busyWrEn) |=> $stable(cpuBusy));

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyWrEn && !strb.capture) |=> (cpuBusy == $past(busyWrVal)));

  // R7
  bad_code_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode[3:0] != 4'h0 && !strobeBusy) |=> !strobeBusy);

endmodule

// File: rtl/pio_host_datapath.sv
module pio_host_datapath
  import pio_host_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic [7:0]   kWrData,
  input  logic [8:0]   ibN,
  output logic [7:0]   kReg,
  output logic [7:0]   abReg,
  output logic         inBit9
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            kReg <= '0;
    else if (strb.capture) kReg <= ~ibN[7:0];
    else if (strb.hostWr)  kReg <= kWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             inBit9 <= 1'b0;
    else if (strb.capture) inBit9 <= ~ibN[8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            abReg <= '0;
    else if (strb.loadAb) abReg <= kReg;
  end

  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadAb |=> $stable(abReg));

  // R10
  capture_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (kReg == ~$past(ibN[7:0])));

  // R2
  host_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hostWr && !strb.capture) |=> (kReg == $past(kWrData)));

endmodule

// File: rtl/pio_host_ctrl.sv
module pio_host_ctrl
  import pio_host_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 200,
  parameter int unsigned SEL_DELAY_NS = 1000,
  parameter int unsigned SEL_WIDTH_NS = 4300,
  parameter int unsigned OUT_WIDTH_NS = 500,
  parameter int unsigned CTL_WIDTH_NS = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       kWrEn,
  input  logic [7:0] kWrData,
  output logic [7:0] kValue,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       busyWrEn,
  input  logic       busyWrVal,
  input  logic [8:0] ibN,
  input  logic       ibsN,
  input  logic       rbN,
  output logic [7:0] obN,
  output logic [7:0] abN,
  output logic       absN,
  output logic       obsN,
  output logic       cbsN,
  output logic       cpbN,
  output logic       devReady,
  output logic       cpuBusy,
  output logic       inBit9,
  output logic       strobeBusy
);
  localparam int unsigned SEL_DELAY_CYC = nsToCycles(SEL_DELAY_NS, CLK_MHZ);
  localparam int unsigned SEL_WIDTH_CYC = nsToCycles(SEL_WIDTH_NS, CLK_MHZ);
  localparam int unsigned OUT_WIDTH_CYC = nsToCycles(OUT_WIDTH_NS, CLK_MHZ);
  localparam int unsigned CTL_WIDTH_CYC = nsToCycles(CTL_WIDTH_NS, CLK_MHZ);

  ctrlStrobes_t strb;
  logic [7:0]   kReg, abReg;
  logic         absOn, obsOn, cbsOn;

  pio_host_control #(
    .SEL_DELAY_CYC(SEL_DELAY_CYC), .SEL_WIDTH_CYC(SEL_WIDTH_CYC),
    .OUT_WIDTH_CYC(OUT_WIDTH_CYC), .CTL_WIDTH_CYC(CTL_WIDTH_CYC)
  ) control (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .kWrEn(kWrEn), .busyWrEn(busyWrEn), .busyWrVal(busyWrVal), .ibsN(ibsN),
    .strb(strb), .absOn(absOn), .obsOn(obsOn), .cbsOn(cbsOn),
    .strobeBusy(strobeBusy), .cpuBusy(cpuBusy));

  pio_host_datapath datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .kWrData(kWrData), .ibN(ibN),
    .kReg(kReg), .abReg(abReg), .inBit9(inBit9));

  assign kValue   = kReg;
  assign obN      = ~kReg;
  assign abN      = ~abReg;
  assign absN     = ~absOn;
  assign obsN     = ~obsOn;
  assign cbsN     = ~cbsOn;
  assign cpbN     = ~cpuBusy;
  assign devReady = ~rbN;

  // R12
  strobe_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!absN || !obsN || !cbsN) |-> strobeBusy);

endmodule

// File: tb/pio_host_ctrl_test.sv
module pio_host_ctrl_test;
  localparam int SD = 200;  // select delay cycles at 200 MHz
  localparam int SW = 860;  // select width cycles
  localparam int OW = 100;  // output strobe width
  localparam int CW = 100;  // control strobe width

  logic clk = 0, rstN = 0;
  logic kWrEn = 0, cmdValid = 0, busyWrEn = 0, busyWrVal = 0, ibsN = 1, rbN = 1;
  logic [7:0] kWrData = 0, cmdCode = 0;
  logic [8:0] ibN = '1;
  logic [7:0] kValue, obN, abN;
  logic absN, obsN, cbsN, cpbN, devReady, cpuBusy, inBit9, strobeBusy;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pio_host_ctrl uut (.*);

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issueCmd(input logic [7:0] code);
    @(negedge clk); cmdValid = 1; cmdCode = code;
    @(negedge clk); cmdValid = 0; cmdCode = 0;
  endtask

  task automatic writeK(input logic [7:0] v);
    @(negedge clk); kWrEn = 1; kWrData = v;
    @(negedge clk); kWrEn = 0;
  endtask

  task automatic testReset();
    check(kValue == 0 && obN == 8'hFF && abN == 8'hFF, "R1 regs", {obN, abN}, 16'hFFFF);
    check({absN, obsN, cbsN} == 3'b111 && cpbN == 0 && !inBit9 && !strobeBusy,
          "R1 ctl", {absN, obsN, cbsN, cpbN, inBit9, strobeBusy}, 16'h38);
  endtask

  task automatic testHostWrite();
    writeK(8'h5A);
    check(kValue == 8'h5A && obN == 8'hA5, "R2", {kValue, obN}, 16'h5AA5);
    rbN = 1;
    writeK(8'h3C);
    check(kValue == 8'h3C, "R8 busy device write", kValue, 8'h3C);
  endtask

  task automatic testSelect();
    writeK(8'h81);
    issueCmd(8'hC0);
    check(abN == 8'h7E, "R3 latch", abN, 8'h7E);
    check(absN == 1 && strobeBusy, "R4 before delay", absN, 1);
    cyc(SD - 1);
    check(absN == 1, "R4 k=D-1", absN, 1);
    cyc(1);
    check(absN == 0, "R4 k=D", absN, 0);
    writeK(8'h22);
    issueCmd(8'h20);
    check(abN == 8'h7E, "R3 hold", abN, 8'h7E);
    cyc(SD + SW - 1 - (SD + 4));
    check(absN == 0, "R4 last low", absN, 0);
    cyc(1);
    check(absN == 1, "R4 end", absN, 1);
    cyc(10);
    check(!strobeBusy, "R12 idle", strobeBusy, 0);
  endtask

  task automatic testOutCtl();
    issueCmd(8'h20);
    check(obsN == 0 && cbsN == 1, "R5 start", {obsN, cbsN}, 16'h1);
    cyc(OW - 1);
    check(obsN == 0, "R5 last", obsN, 0);
    cyc(1);
    check(obsN == 1, "R5 end", obsN, 1);
    issueCmd(8'h10);
    check(cbsN == 0 && obsN == 1, "R6 start", {cbsN, obsN}, 16'h1);
    cyc(CW - 1);
    check(cbsN == 0, "R6 last", cbsN, 0);
    cyc(1);
    check(cbsN == 1 && absN == 1, "R6 end", cbsN, 1);
  endtask

  task automatic testBadCode();
    writeK(8'h44);
    issueCmd(8'hF1);
    check({absN, obsN, cbsN} == 3'b111 && !strobeBusy && abN == 8'h7E, "R7 ignored",
          {abN, 5'b0, absN, obsN, cbsN}, 16'h7E07);
    cyc(SD + 2);
    check(absN == 1 && abN == 8'h7E, "R7 no select", {abN, 7'b0, absN}, 16'h7E01);
  endtask

  task automatic testRetrigger();
    issueCmd(8'h20);
    cyc(50);
    issueCmd(8'h20);
    cyc(OW - 1);
    check(obsN == 0, "R8 retrigger held", obsN, 0);
    cyc(1);
    check(obsN == 1, "R8 retrigger end", obsN, 1);
  endtask

  task automatic testBusyAndCapture();
    @(negedge clk); busyWrEn = 1; busyWrVal = 0;
    @(negedge clk); busyWrEn = 0;
    check(cpbN == 1 && !cpuBusy, "R9 clear", {cpbN, cpuBusy}, 16'h2);
    @(negedge clk); ibN = ~9'h1C3; ibsN = 0;
    @(negedge clk);
    check(kValue == 8'hC3 && inBit9 && cpuBusy && cpbN == 0, "R10 capture",
          {kValue, 6'b0, inBit9, cpuBusy}, 16'hC303);
    ibN = ~9'h011;
    cyc(3);
    check(kValue == 8'hC3, "R10 single capture", kValue, 8'hC3);
    ibsN = 1;
    @(negedge clk); busyWrEn = 1; busyWrVal = 0;
    @(negedge clk); busyWrEn = 0;
    @(negedge clk); ibN = ~9'h066; ibsN = 0; kWrEn = 1; kWrData = 8'h99; busyWrEn = 1; busyWrVal = 0;
    @(negedge clk); kWrEn = 0; busyWrEn = 0; ibsN = 1;
    check(kValue == 8'h66 && cpuBusy && !inBit9, "R11 capture wins",
          {kValue, 6'b0, inBit9, cpuBusy}, 16'h6601);
  endtask

  task automatic testReady();
    rbN = 0; #1;
    check(devReady == 1, "R12 ready", devReady, 1);
    rbN = 1; #1;
    check(devReady == 0, "R12 busy dev", devReady, 0);
  endtask

  initial begin
    cyc(3);
    testReset();
    @(negedge clk); rstN = 1;
    testHostWrite();
    testSelect();
    testOutCtl();
    testBadCode();
    testRetrigger();
    testBusyAndCapture();
    testReady();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule